// File: doc/BRIEF.md
# Mirrored Card Register Window Decoder

This block sits inside a 64 KB expansion card and turns bus addresses into card-side chip selects and register accesses. The card space is cut into four 16 KB segments. The lowest segment holds the board-identification data and the card's own registers. The other three segments serve a peripheral, a ROM and a shared RAM. Before the host configures the card, it answers only at a fixed configuration address, and only while the daisy-chain enable is high. The host then writes the base register. From that point the card answers only at the base it was given, and it raises its chain output so that the next card can be configured.

The card's own registers never share one address between a read and a write. Each register has a write copy in one bank and a read copy in another bank 2 KB higher. A fast processor that writes a register and then reads it back therefore always starts a new bus cycle at a different location. Two further banks give the same registers with the byte order reversed, for peripherals that use little-endian data. Every register sits on a longword boundary. Every register accepts a full 32-bit write and keeps only the bits it implements.

Top module: `card_window_dec`

## Requirements
- R1: After reset, every select, `rd_data`, `ctrl_out`, `timing_out`, `irq_out` and `cfg_out` is zero.
- R2: While unconfigured, the card decodes only when `chain_in` is high and `bus_addr[23:16]` equals the configuration base (default 0xE8). In that state only `sel_acinfo` and the card's own registers can respond, so `sel_periph`, `sel_rom` and `sel_ram` stay low.
- R3: A write to card offset 0x2000 (base register) loads `bus_wdata[7:0]` as the new base and sets `cfg_out` one cycle later. From then on, the card decodes only where `bus_addr[23:16]` equals that base and no longer answers at the configuration address. A later write to the base register moves the card again.
- R4: The selects are combinational and gated by `bus_valid` and an address match. Offset bits [15:14] pick the segment: 0 gives `sel_acinfo` (for offsets 0x0000 to 0x1FFF only), 1 gives `sel_periph`, 2 gives `sel_rom` and 3 gives `sel_ram`. At most one select is high at a time.
- R5: Register i is written at offset 0x2000+4i and read at offset 0x2800+4i. A read from the write bank returns zero. A write to the read bank changes nothing.
- R6: Read data appears on `rd_data` in the cycle after the read strobe and then holds until the next read. Any read that is not an implemented register in a read bank returns zero; this covers write-only registers, unused indices and non-register segments.
- R7: Register 1 (control) is write-only and drives `ctrl_out` from data bits [7:0]. Register 2 (timing) is write-only and drives `timing_out` from data bits [1:0]. The upper bits of a 32-bit write are discarded.
- R8: Register 4 is a 32-bit scratch register: a value written through the write bank reads back unchanged through the read bank.
- R9: Offsets 0x3000+4i (write) and 0x3800+4i (read) reach the same registers with the data bytes reversed, so byte 0 is exchanged with byte 3 and byte 1 with byte 2.
- R10: Register 3 (status) is read-only. Bit 0 is set by `irq_in` being high at a clock edge and is copied to `irq_out`. It clears when bit 0 of a write to the status write address is a one. A write of zero to that bit has no effect, and a set in the same cycle as a clear wins.
- R11: A register access with `bus_addr[1:0]` not zero is ignored: it writes nothing and reads zero.
- R12: `rst_n` clears the block asynchronously. The release of reset is synchronized, and registers start to update on the third rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_in | input | 1 | Configuration daisy-chain enable from the previous slot |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data |
| irq_in | input | 1 | Interrupt request from the card peripheral |
| rd_data | output | 32 | Registered register read data |
| sel_acinfo | output | 1 | Select for board-identification data |
| sel_periph | output | 1 | Select for the peripheral segment |
| sel_rom | output | 1 | Select for the ROM segment |
| sel_ram | output | 1 | Select for the shared RAM segment |
| ctrl_out | output | 8 | Control register contents |
| timing_out | output | 2 | Timing-mode register contents |
| irq_out | output | 1 | Latched interrupt state |
| cfg_out | output | 1 | Card configured; chain enable for the next slot |

## Verification
If the configured flag or the base register holds a wrong value, the selects come up at the wrong address range or stay silent. This shows in the same cycle as the next access, because the selects are combinational. If a register's state is wrong, or a bank is decoded wrongly, the fault appears on `rd_data` one cycle after the read of that register. Faults in the control and timing registers appear on `ctrl_out` and `timing_out` one cycle after the write. A wrong interrupt latch appears on `irq_out` one edge after the set or the clear.

// File: rtl/card_win_pkg.sv
package card_win_pkg;

  // Register indices inside each bank (longword stride)
  typedef enum logic [2:0] {
    RI_BASE = 3'd0,
    RI_CTRL = 3'd1,
    RI_TIME = 3'd2,
    RI_STAT = 3'd3,
    RI_SCR  = 3'd4
  } reg_idx_e;

  // Segment numbers in offset bits [CARD_W-1:CARD_W-2]
  localparam int unsigned SEG_ID   = 0;
  localparam int unsigned SEG_PER  = 1;
  localparam int unsigned SEG_ROM  = 2;
  localparam int unsigned SEG_RAM  = 3;
  localparam int unsigned NUM_SEG  = 4;

  function automatic logic [31:0] bswap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

endpackage

// File: rtl/card_addr_match.sv
module card_addr_match #(
  parameter int unsigned BASE_W   = 8,
  parameter int unsigned CFG_BASE = 'hE8
) (
  input  logic [BASE_W-1:0] addr_hi,
  input  logic              chain_in,
  input  logic              configured,
  input  logic [BASE_W-1:0] base,
  output logic              hit
);

  localparam logic [BASE_W-1:0] CfgHi = BASE_W'(CFG_BASE);

  logic cfg_hit;
  logic run_hit;

  always_comb begin
    cfg_hit = chain_in && !configured && (addr_hi == CfgHi);
    run_hit = configured && (addr_hi == base);
    hit     = cfg_hit || run_hit;
  end

endmodule

// File: rtl/card_seg_decode.sv
module card_seg_decode
  import card_win_pkg::*;
(
  input  logic               valid,
  input  logic               hit,
  input  logic               configured,
  input  logic [1:0]         seg,
  input  logic               upper_half,
  input  logic [1:0]         low_bits,
  output logic [NUM_SEG-1:0] sel,
  output logic               reg_acc
);

  logic base_ok;

  always_comb begin
    base_ok = valid && hit;
    sel[SEG_ID] = base_ok && (seg == 2'(SEG_ID)) && !upper_half;
    reg_acc     = base_ok && (seg == 2'(SEG_ID)) && upper_half && (low_bits == 2'b00);
  end

  // Device segments only respond on a configured card
  for (genvar g = 1; g < NUM_SEG; g++) begin : g_dev_sel
    always_comb sel[g] = base_ok && configured && (seg == 2'(g));
  end

endmodule

// File: rtl/card_reg_file.sv
module card_reg_file
  import card_win_pkg::*;
#(
  parameter int unsigned OFF_W  = 13,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned TIM_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              rd_stb,
  input  logic              we,
  input  logic [OFF_W-1:2]  off,
  input  logic [31:0]       wdata,
  input  logic              irq_in,
  output logic [BASE_W-1:0] base,
  output logic              configured,
  output logic [CTRL_W-1:0] ctrl,
  output logic [TIM_W-1:0]  timing,
  output logic              irq_pend,
  output logic [31:0]       rd_data
);

  localparam int unsigned IDX_W = OFF_W - 4;

  logic              bank_sw, bank_rd;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       wd_eff;
  logic              wr_ok, rd_ok;
  logic [31:0]       rd_val, rd_val_bus;

  logic [BASE_W-1:0] base_q, base_d;
  logic              cfg_q, cfg_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [TIM_W-1:0]  tim_q, tim_d;
  logic              irq_q, irq_d;
  logic [31:0]       scr_q, scr_d;
  logic [31:0]       rdq, rdd;
  logic              en_ctrl_state;

  always_comb begin
    bank_sw = off[OFF_W-1];
    bank_rd = off[OFF_W-2];
    idx     = off[OFF_W-3:2];
    wd_eff  = bank_sw ? bswap32(wdata) : wdata;
    wr_ok   = acc && we && !bank_rd;
    rd_ok   = acc && !we && bank_rd;
  end

  // Next-state for the writable registers
  always_comb begin
    base_d = base_q;
    cfg_d  = cfg_q;
    ctrl_d = ctrl_q;
    tim_d  = tim_q;
    scr_d  = scr_q;
    en_ctrl_state = wr_ok;
    if (wr_ok) begin
      unique case (idx)
        IDX_W'(RI_BASE): begin
          base_d = wd_eff[BASE_W-1:0];
          cfg_d  = 1'b1;
        end
        IDX_W'(RI_CTRL): ctrl_d = wd_eff[CTRL_W-1:0];
        IDX_W'(RI_TIME): tim_d  = wd_eff[TIM_W-1:0];
        IDX_W'(RI_SCR):  scr_d  = wd_eff;
        default: ;
      endcase
    end
  end

  // Interrupt latch: set dominates clear
  always_comb begin
    irq_d = irq_in ||
            (irq_q && !(wr_ok && (idx == IDX_W'(RI_STAT)) && wd_eff[0]));
  end

  // Read path
  always_comb begin
    unique case (idx)
      IDX_W'(RI_BASE): rd_val = 32'(base_q);
      IDX_W'(RI_STAT): rd_val = {31'd0, irq_q};
      IDX_W'(RI_SCR):  rd_val = scr_q;
      default:         rd_val = 32'd0;
    endcase
    rd_val_bus = bank_sw ? bswap32(rd_val) : rd_val;
    rdd = rdq;
    if (rd_stb) rdd = rd_ok ? rd_val_bus : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= 1'b0;
      ctrl_q <= '0;
      tim_q  <= '0;
      scr_q  <= '0;
    end else if (en_ctrl_state) begin
      base_q <= base_d;
      cfg_q  <= cfg_d;
      ctrl_q <= ctrl_d;
      tim_q  <= tim_d;
      scr_q  <= scr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rdq   <= '0;
    end else begin
      irq_q <= irq_d;
      if (rd_stb) rdq <= rdd;
    end
  end

  always_comb begin
    base       = base_q;
    configured = cfg_q;
    ctrl       = ctrl_q;
    timing     = tim_q;
    irq_pend   = irq_q;
    rd_data    = rdq;
  end

endmodule

// File: rtl/card_window_dec.sv
module card_window_dec
  import card_win_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned CARD_W   = 16,
  parameter int unsigned CFG_BASE = 'hE8,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned TIM_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_in,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              irq_in,
  output logic [31:0]       rd_data,
  output logic              sel_acinfo,
  output logic              sel_periph,
  output logic              sel_rom,
  output logic              sel_ram,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [TIM_W-1:0]  timing_out,
  output logic              irq_out,
  output logic              cfg_out
);

  localparam int unsigned BASE_W = ADDR_W - CARD_W;
  localparam int unsigned OFF_W  = CARD_W - 3;

  logic              rst_s1_n, rst_q_n;
  logic              hit, reg_acc, configured;
  logic [BASE_W-1:0] base;
  logic [NUM_SEG-1:0] sel;

  // Reset: asynchronous assert, synchronized release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  card_addr_match #(.BASE_W(BASE_W), .CFG_BASE(CFG_BASE)) u_match (
    .addr_hi    (bus_addr[ADDR_W-1:CARD_W]),
    .chain_in   (chain_in),
    .configured (configured),
    .base       (base),
    .hit        (hit)
  );

  card_seg_decode u_seg (
    .valid      (bus_valid),
    .hit        (hit),
    .configured (configured),
    .seg        (bus_addr[CARD_W-1:CARD_W-2]),
    .upper_half (bus_addr[CARD_W-3]),
    .low_bits   (bus_addr[1:0]),
    .sel        (sel),
    .reg_acc    (reg_acc)
  );

  card_reg_file #(
    .OFF_W(OFF_W), .BASE_W(BASE_W), .CTRL_W(CTRL_W), .TIM_W(TIM_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .acc        (reg_acc),
    .rd_stb     (bus_valid && !bus_we),
    .we         (bus_we),
    .off        (bus_addr[OFF_W-1:2]),
    .wdata      (bus_wdata),
    .irq_in     (irq_in),
    .base       (base),
    .configured (configured),
    .ctrl       (ctrl_out),
    .timing     (timing_out),
    .irq_pend   (irq_out),
    .rd_data    (rd_data)
  );

  always_comb begin
    sel_acinfo = sel[SEG_ID];
    sel_periph = sel[SEG_PER];
    sel_rom    = sel[SEG_ROM];
    sel_ram    = sel[SEG_RAM];
    cfg_out    = configured;
  end

endmodule

// File: rtl/card_window_chk.sv
module card_window_chk #(
  parameter int unsigned CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic              irq_in,
  input logic              sel_acinfo,
  input logic              sel_periph,
  input logic              sel_rom,
  input logic              sel_ram,
  input logic [CTRL_W-1:0] ctrl_out,
  input logic [31:0]       rd_data,
  input logic              irq_out,
  input logic              cfg_out
);

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_acinfo, sel_periph, sel_rom, sel_ram}));

  assert_sel_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !(sel_acinfo || sel_periph || sel_rom || sel_ram));

  assert_unconf_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_out |-> !(sel_periph || sel_rom || sel_ram));

  assert_cfg_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out |=> cfg_out);

  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |=> irq_out);

  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> $stable(ctrl_out));

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_we) |=> $stable(rd_data));

endmodule

bind card_window_dec card_window_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .bus_valid  (bus_valid),
  .bus_we     (bus_we),
  .irq_in     (irq_in),
  .sel_acinfo (sel_acinfo),
  .sel_periph (sel_periph),
  .sel_rom    (sel_rom),
  .sel_ram    (sel_ram),
  .ctrl_out   (ctrl_out),
  .rd_data    (rd_data),
  .irq_out    (irq_out),
  .cfg_out    (cfg_out)
);

// File: tb/tb_card_window_dec.sv
module tb_card_window_dec;

  localparam int CLK_NS = 20;

  logic        clk;
  logic        rst_n;
  logic        chain_in;
  logic        bus_valid;
  logic        bus_we;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        irq_in;
  logic [31:0] rd_data;
  logic        sel_acinfo, sel_periph, sel_rom, sel_ram;
  logic [7:0]  ctrl_out;
  logic [1:0]  timing_out;
  logic        irq_out;
  logic        cfg_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  logic [3:0] sel_seen;

  card_window_dec dut (
    .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq_in(irq_in), .rd_data(rd_data), .sel_acinfo(sel_acinfo),
    .sel_periph(sel_periph), .sel_rom(sel_rom), .sel_ram(sel_ram),
    .ctrl_out(ctrl_out), .timing_out(timing_out), .irq_out(irq_out),
    .cfg_out(cfg_out)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] bsw(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // Expected select vector {ram, rom, periph, acinfo}
  function automatic logic [3:0] exp_sel(input logic [15:0] off, input bit conf);
    logic [1:0] s;
    s = off[15:14];
    if (s == 2'd0) return (off < 16'h2000) ? 4'b0001 : 4'b0000;
    if (!conf) return 4'b0000;
    return 4'b0001 << s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One-cycle access; selects captured mid-cycle, registered results visible on return
  task automatic access(input bit we, input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1 sel_seen = {sel_ram, sel_rom, sel_periph, sel_acinfo};
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a);
    access(1'b0, a, 32'h0);
  endtask

  localparam logic [23:0] CFGA = 24'hE80000;
  localparam logic [23:0] BASA = 24'h200000;

  initial begin
    rst_n = 1'b0; chain_in = 1'b0; bus_valid = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; irq_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outs", {rd_data[7:0], ctrl_out, 6'd0, timing_out, 4'd0,
                      sel_ram, sel_rom, sel_periph, sel_acinfo, 2'd0, irq_out, cfg_out}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);   // R12 synchronized release

    // R2: no chain enable, no decode
    access(1'b0, CFGA, 0);
    check("R2 chain low", 32'(sel_seen), 32'h0);
    chain_in = 1'b1;
    for (int k = 0; k < 16; k++) begin
      access(1'b0, CFGA | 24'(k * 16'h1000), 0);
      check("R2 unconfigured sweep", 32'(sel_seen), 32'(exp_sel(16'(k * 16'h1000), 1'b0)));
    end
    access(1'b0, 24'h200000, 0);
    check("R2 wrong base", 32'(sel_seen), 32'h0);

    // R3 configure at base 0x20 (upper data bits ignored)
    access(1'b1, CFGA | 24'h2000, 32'hFFFFFF20);
    check("R3 cfg_out", 32'(cfg_out), 32'h1);
    rd(BASA | 24'h2800);
    check("R3 base readback", rd_data, 32'h20);
    access(1'b0, CFGA, 0);
    check("R3 old addr silent", 32'(sel_seen), 32'h0);
    // R4 full sweep at new base, including a non-matching base
    for (int k = 0; k < 16; k++) begin
      access(1'b0, BASA | 24'(k * 16'h1000), 0);
      check("R4 configured sweep", 32'(sel_seen), 32'(exp_sel(16'(k * 16'h1000), 1'b1)));
      access(1'b0, 24'h210000 | 24'(k * 16'h1000), 0);
      check("R4 foreign base", 32'(sel_seen), 32'h0);
    end
    // R6 read of non-register segment returns zero
    rd(BASA | 24'h4000);
    check("R6 device segment read", rd_data, 32'h0);

    // R7 write-only control and timing
    access(1'b1, BASA | 24'h2004, 32'hABCDEF5A);
    check("R7 ctrl", 32'(ctrl_out), 32'h5A);
    rd(BASA | 24'h2804);
    check("R7/R6 ctrl reads zero", rd_data, 32'h0);
    access(1'b1, BASA | 24'h2008, 32'hFFFFFFFE);
    check("R7 timing", 32'(timing_out), 32'h2);
    rd(BASA | 24'h2808);
    check("R6 timing reads zero", rd_data, 32'h0);

    // R8/R9 scratch round trips
    for (int p = 0; p < 6; p++) begin
      logic [31:0] v;
      v = 32'h1234_5678 ^ (32'hA5C3_0F81 * (p + 1));
      access(1'b1, BASA | 24'h2010, v);
      rd(BASA | 24'h2810);
      check("R8 scratch", rd_data, v);
      rd(BASA | 24'h3810);
      check("R9 swapped read", rd_data, bsw(v));
      access(1'b1, BASA | 24'h3010, v);
      rd(BASA | 24'h2810);
      check("R9 swapped write", rd_data, bsw(v));
    end
    // R5 bank separation
    access(1'b1, BASA | 24'h2010, 32'hCAFEF00D);
    rd(BASA | 24'h2010);
    check("R5 write bank reads zero", rd_data, 32'h0);
    access(1'b1, BASA | 24'h2810, 32'h11111111);
    rd(BASA | 24'h2810);
    check("R5 read bank write ignored", rd_data, 32'hCAFEF00D);
    // R11 misaligned
    access(1'b1, BASA | 24'h2012, 32'h22222222);
    rd(BASA | 24'h2810);
    check("R11 misaligned write ignored", rd_data, 32'hCAFEF00D);
    rd(BASA | 24'h2812);
    check("R11 misaligned read zero", rd_data, 32'h0);
    access(1'b1, BASA | 24'h2005, 32'h000000FF);
    check("R11 ctrl untouched", 32'(ctrl_out), 32'h5A);
    // R6 unused indices
    for (int i = 5; i < 12; i++) begin
      rd(BASA | 24'h2800 | 24'(4 * i));
      check("R6 unused index", rd_data, 32'h0);
    end

    // R10 interrupt latch
    @(negedge clk); irq_in = 1'b1;
    @(negedge clk); irq_in = 1'b0;
    check("R10 irq set", 32'(irq_out), 32'h1);
    rd(BASA | 24'h280C);
    check("R10 status read", rd_data, 32'h1);
    access(1'b1, BASA | 24'h200C, 32'hFFFFFFFE);
    check("R10 write zero no effect", 32'(irq_out), 32'h1);
    irq_in = 1'b1;
    access(1'b1, BASA | 24'h200C, 32'h1);
    irq_in = 1'b0;
    check("R10 set wins", 32'(irq_out), 32'h1);
    access(1'b1, BASA | 24'h200C, 32'h1);
    check("R10 clear", 32'(irq_out), 32'h0);
    @(negedge clk); irq_in = 1'b1;
    @(negedge clk); irq_in = 1'b0;
    access(1'b1, BASA | 24'h300C, 32'h01000000);
    check("R10 swapped clear", 32'(irq_out), 32'h0);
    access(1'b1, BASA | 24'h280C, 32'h0);
    rd(BASA | 24'h380C);
    check("R10 status swapped read", rd_data, 32'h0);

    // R3 relocate again
    access(1'b1, BASA | 24'h2000, 32'h00000031);
    access(1'b0, 24'h314000, 0);
    check("R3 relocated", 32'(sel_seen), 32'b0010);
    access(1'b0, BASA | 24'h4000, 0);
    check("R3 old base silent", 32'(sel_seen), 32'h0);

    // R12/R1 asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1 check("R12 async clear", {24'd0, ctrl_out}, 32'h0);
    check("R1 cfg cleared", 32'(cfg_out), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule